// File: doc/BRIEF.md
# Character-Synchronous Serial Receiver with Double-Sync Hunt

This block receives a character-oriented synchronous serial stream, one bit per rising edge of `clk`, least significant bit first. Once enabled, it slides a window over the incoming bits until the window equals the programmed sync character. It then expects a second sync character exactly one character later before it treats anything as data. After that it delivers each complete character, right-aligned, into a host-visible data register. It raises a data-available flag, and it raises an overrun flag when the host falls behind.

Leading syncs can optionally be discarded. Each character can optionally carry a parity bit that is checked and then removed. A CRC-16 can optionally be run over the message, and its pass indication lasts one character time. Once the receiver has synchronized it stays active until `rx_en` is dropped, which returns every register to its idle value. The asynchronous reset is released synchronously inside the block.

Top module: `bsync_rx`

## Requirements
- R1: After `rx_en` rises, the receiver compares the last F received bits against the low F bits of `sync_pat` on every clock, where F is the frame length. After the first match it compares the character completed exactly F bits later. If that character is not a sync, it returns to the bit-by-bit search. `rx_active` stays 0 until the first data character is delivered.
- R2: With `strip_en`=0, the character that follows the second sync is the first data character, even when it equals the sync pattern.
- R3: With `strip_en`=1, sync characters that directly follow the opening pair are discarded. The first non-sync character is delivered as the first data character. Sync characters that arrive later in the message are delivered as data.
- R4: `sync_det` is high for exactly one clock after each recognized sync: the hunt match, the second sync, and any sync completed on a character boundary afterwards.
- R5: `len_sel` selects the data bits per character: 00=5, 01=6, 10=7, 11=8. Bits arrive LSB first. `rx_char` holds the data right-aligned, with the upper bits zero. Only the low F bits of `sync_pat` take part in the comparison.
- R6: `data_avail` and the new `rx_char` appear on the same edge that samples the last bit of a character. A one-clock `rd_data` pulse clears `data_avail`.
- R7: A character that completes while `data_avail` is still set, with no `rd_data` on that clock, is dropped. `rx_char` keeps its old value, and `st_overrun` sets and holds until `rd_stat`.
- R8: With `chk_mode`=01, each character carries a parity bit after its data bits, so F = data bits + 1. With `len_sel`=11 the data length is 7. The parity bit is XOR of the data when `par_odd`=0, and its inverse when `par_odd`=1. A mismatch sets `st_error` until `rd_stat`. The parity bit never appears in `rx_char`.
- R9: With `chk_mode`=10, a CRC over x^16+x^15+x^2+1 is computed bit-reflected, preset to zero, across every delivered character. `st_error` is 1 for the character time after a character that leaves a zero remainder, and 0 otherwise.
- R10: `stat_avail` sets when `st_overrun` or the parity error goes from 0 to 1, and `rd_stat` clears it. The CRC indication never sets it.
- R11: While synchronized with `rx_en` high, `rx_active` stays 1. Dropping `rx_en` clears `rx_active`, `data_avail`, `stat_avail`, the status bits, `rx_char` and the hunt state on the next edge.
- R12: While `rst_n` is low, every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Receive bit clock; one serial bit per rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_en | input | 1 | Receiver enable; low holds the receiver idle |
| rx_sd | input | 1 | Serial data, LSB of each character first |
| sync_pat | input | 8 | Programmed sync character (low F bits used) |
| len_sel | input | 2 | Data bits per character: 5 + code |
| strip_en | input | 1 | Discard syncs that follow the opening pair |
| chk_mode | input | 2 | 00 none, 01 parity, 10 CRC-16 |
| par_odd | input | 1 | Parity sense in parity mode: 1 odd, 0 even |
| rd_data | input | 1 | Host read strobe for the data register |
| rd_stat | input | 1 | Host read strobe for the status bits |
| rx_char | output | 8 | Received character, right-aligned |
| data_avail | output | 1 | A character is waiting in `rx_char` |
| stat_avail | output | 1 | A status bit has newly set |
| st_overrun | output | 1 | A character was lost |
| st_error | output | 1 | Parity error, or CRC pass in CRC mode |
| sync_det | output | 1 | One-clock pulse per recognized sync |
| rx_active | output | 1 | Receiver synchronized and delivering data |

## Verification
The bench sends a lone sync followed by a non-sync character. A receiver that locked on one sync would go active there. It sends a third sync with stripping off, which a receiver that strips unconditionally would swallow. It sends a sync in mid-message with stripping on, which a receiver that strips throughout would lose. In parity mode it checks that the parity bit is stripped and that a bad parity raises both error and status-available. In CRC mode it checks that the pass indication appears after the second check byte and is gone one character later, without touching status-available. An overrun must keep the first character, flag the loss, and recover after both reads.

// File: rtl/bsr_pkg.sv
package bsr_pkg;

  localparam int unsigned CHAR_W   = 8;
  localparam int unsigned CRC_W    = 16;
  // x^16 + x^15 + x^2 + 1, bit-reversed for LSB-first processing
  localparam logic [CRC_W-1:0] CRC_POLY_REFL = 16'hA001;

  typedef enum logic [1:0] {
    ST_HUNT1 = 2'd0,
    ST_HUNT2 = 2'd1,
    ST_FIRST = 2'd2,
    ST_RUN   = 2'd3
  } hunt_st_e;

  typedef enum logic [1:0] {
    CHK_NONE = 2'b00,
    CHK_VRC  = 2'b01,
    CHK_CRC  = 2'b10,
    CHK_RSVD = 2'b11
  } chk_e;

  // Fold the low n bits of d, LSB first, into a reflected CRC.
  function automatic logic [CRC_W-1:0] crc_fold(input logic [CRC_W-1:0] c,
                                                input logic [CHAR_W-1:0] d,
                                                input logic [3:0] n);
    logic [CRC_W-1:0] r;
    logic fb;
    r = c;
    for (int i = 0; i < CHAR_W; i++) begin
      if (4'(i) < n) begin
        fb = r[0] ^ d[i];
        r  = r >> 1;
        if (fb) r = r ^ CRC_POLY_REFL;
      end
    end
    return r;
  endfunction

endpackage

// File: rtl/bsr_framer.sv
module bsr_framer #(
  parameter int unsigned MAX_W = 8,
  localparam int unsigned CW = $clog2(MAX_W + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic             rx_sd,
  input  logic             hunt,
  input  logic [CW-1:0]    frame_len,
  input  logic [MAX_W-1:0] sync_pat,
  output logic [MAX_W-1:0] frame,
  output logic             hunt_hit,
  output logic             char_done,
  output logic             frame_is_sync
);

  logic [MAX_W-1:0] sr_q, sr_n;
  logic [CW-1:0]    fill_q, fill_n;
  logic [CW-1:0]    bcnt_q, bcnt_n;
  logic [MAX_W-1:0] len_mask;
  logic             fill_ok;

  always_comb begin
    sr_n          = {rx_sd, sr_q[MAX_W-1:1]};
    frame         = sr_n >> (CW'(MAX_W) - frame_len);
    len_mask      = ~({MAX_W{1'b1}} << frame_len);
    frame_is_sync = (((frame ^ sync_pat) & len_mask) == '0);
    fill_ok       = (({1'b0, fill_q} + 1'b1) >= {1'b0, frame_len});
    hunt_hit      = enable & hunt & fill_ok & frame_is_sync;
    char_done     = enable & ~hunt & (bcnt_q == (frame_len - 1'b1));
    fill_n        = (fill_q == CW'(MAX_W)) ? fill_q : fill_q + 1'b1;
    bcnt_n        = (hunt | char_done) ? '0 : bcnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr_q   <= '0;
      fill_q <= '0;
      bcnt_q <= '0;
    end else if (!enable) begin
      sr_q   <= '0;
      fill_q <= '0;
      bcnt_q <= '0;
    end else begin
      sr_q   <= sr_n;
      fill_q <= fill_n;
      bcnt_q <= bcnt_n;
    end
  end

endmodule

// File: rtl/bsr_sync_fsm.sv
module bsr_sync_fsm
  import bsr_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic enable,
  input  logic strip_en,
  input  logic hunt_hit,
  input  logic char_done,
  input  logic frame_is_sync,
  output logic hunt,
  output logic crc_clr,
  output logic deliver,
  output logic sync_det,
  output logic rx_active
);

  hunt_st_e state_q, state_n;
  logic     sd_n;

  always_comb begin
    state_n = state_q;
    deliver = 1'b0;
    sd_n    = 1'b0;
    unique case (state_q)
      ST_HUNT1: begin
        if (hunt_hit) begin
          sd_n    = 1'b1;
          state_n = ST_HUNT2;
        end
      end
      ST_HUNT2: begin
        if (char_done) begin
          if (frame_is_sync) begin
            sd_n    = 1'b1;
            state_n = ST_FIRST;
          end else begin
            state_n = ST_HUNT1;
          end
        end
      end
      ST_FIRST: begin
        if (char_done) begin
          sd_n = frame_is_sync;
          if (!(strip_en && frame_is_sync)) begin
            deliver = 1'b1;
            state_n = ST_RUN;
          end
        end
      end
      ST_RUN: begin
        if (char_done) begin
          sd_n    = frame_is_sync;
          deliver = 1'b1;
        end
      end
      default: state_n = ST_HUNT1;
    endcase
    hunt    = (state_q == ST_HUNT1);
    crc_clr = (state_q == ST_HUNT1) || (state_q == ST_HUNT2);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_HUNT1;
      sync_det  <= 1'b0;
      rx_active <= 1'b0;
    end else if (!enable) begin
      state_q   <= ST_HUNT1;
      sync_det  <= 1'b0;
      rx_active <= 1'b0;
    end else begin
      state_q   <= state_n;
      sync_det  <= sd_n;
      rx_active <= (state_n == ST_RUN);
    end
  end

endmodule

// File: rtl/bsr_char_check.sv
module bsr_char_check
  import bsr_pkg::*;
#(
  parameter int unsigned MAX_W = 8,
  localparam int unsigned CW = $clog2(MAX_W + 1),
  localparam int unsigned IW = $clog2(MAX_W)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic [1:0]       chk_mode,
  input  logic             par_odd,
  input  logic [MAX_W-1:0] frame,
  input  logic [CW-1:0]    data_len,
  input  logic             crc_clr,
  input  logic             deliver,
  output logic [MAX_W-1:0] data,
  output logic             vrc_bad,
  output logic             crc_ok
);

  logic [CRC_W-1:0] crc_q, crc_n;
  logic             crc_ok_n;
  logic             par_bit, par_exp;

  always_comb begin
    data     = frame & ~({MAX_W{1'b1}} << data_len);
    par_bit  = frame[data_len[IW-1:0]];
    par_exp  = (^data) ^ par_odd;
    vrc_bad  = deliver && (chk_mode == CHK_VRC) && (par_bit != par_exp);
    crc_n    = crc_q;
    crc_ok_n = crc_ok;
    if (crc_clr) begin
      crc_n    = '0;
      crc_ok_n = 1'b0;
    end else if (deliver) begin
      if (chk_mode == CHK_CRC) begin
        crc_n = crc_fold(crc_q, CHAR_W'(data), 4'(data_len));
      end
      crc_ok_n = (chk_mode == CHK_CRC) && (crc_n == '0);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      crc_q  <= '0;
      crc_ok <= 1'b0;
    end else if (!enable) begin
      crc_q  <= '0;
      crc_ok <= 1'b0;
    end else begin
      crc_q  <= crc_n;
      crc_ok <= crc_ok_n;
    end
  end

endmodule

// File: rtl/bsr_host_regs.sv
module bsr_host_regs #(
  parameter int unsigned MAX_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic             deliver,
  input  logic [MAX_W-1:0] data,
  input  logic             vrc_bad,
  input  logic             crc_ok,
  input  logic             rd_data,
  input  logic             rd_stat,
  output logic [MAX_W-1:0] rx_char,
  output logic             data_avail,
  output logic             stat_avail,
  output logic             st_overrun,
  output logic             st_error
);

  logic             verr_q;
  logic             avail_kept, ovr_kept, verr_kept;
  logic             lost, load, rise;
  logic [MAX_W-1:0] char_n;
  logic             avail_n, ovr_n, verr_n, stat_n;

  always_comb begin
    avail_kept = data_avail & ~rd_data;
    ovr_kept   = st_overrun & ~rd_stat;
    verr_kept  = verr_q & ~rd_stat;
    lost       = deliver & avail_kept;
    load       = deliver & ~avail_kept;
    char_n     = load ? data : rx_char;
    avail_n    = avail_kept | load;
    ovr_n      = ovr_kept | lost;
    verr_n     = verr_kept | vrc_bad;
    rise       = (lost & ~ovr_kept) | (vrc_bad & ~verr_kept);
    stat_n     = (stat_avail & ~rd_stat) | rise;
  end

  assign st_error = verr_q | crc_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_char    <= '0;
      data_avail <= 1'b0;
      st_overrun <= 1'b0;
      verr_q     <= 1'b0;
      stat_avail <= 1'b0;
    end else if (!enable) begin
      rx_char    <= '0;
      data_avail <= 1'b0;
      st_overrun <= 1'b0;
      verr_q     <= 1'b0;
      stat_avail <= 1'b0;
    end else begin
      rx_char    <= char_n;
      data_avail <= avail_n;
      st_overrun <= ovr_n;
      verr_q     <= verr_n;
      stat_avail <= stat_n;
    end
  end

endmodule

// File: rtl/bsync_rx.sv
module bsync_rx
  import bsr_pkg::*;
#(
  parameter int unsigned MAX_W = CHAR_W,
  localparam int unsigned CW = $clog2(MAX_W + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rx_en,
  input  logic             rx_sd,
  input  logic [MAX_W-1:0] sync_pat,
  input  logic [1:0]       len_sel,
  input  logic             strip_en,
  input  logic [1:0]       chk_mode,
  input  logic             par_odd,
  input  logic             rd_data,
  input  logic             rd_stat,
  output logic [MAX_W-1:0] rx_char,
  output logic             data_avail,
  output logic             stat_avail,
  output logic             st_overrun,
  output logic             st_error,
  output logic             sync_det,
  output logic             rx_active
);

  logic [1:0]       rst_sync_q;
  logic             rst_int_n;
  logic             vrc_mode;
  logic [CW-1:0]    data_len, frame_len;
  logic [MAX_W-1:0] frame, data;
  logic             hunt, crc_clr, deliver;
  logic             hunt_hit, char_done, frame_is_sync;
  logic             vrc_bad, crc_ok;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  always_comb begin
    vrc_mode  = (chk_mode == CHK_VRC);
    data_len  = (vrc_mode && (len_sel == 2'b11)) ? CW'(7) : CW'(5) + CW'(len_sel);
    frame_len = data_len + CW'(vrc_mode);
  end

  bsr_framer #(.MAX_W(MAX_W)) u_framer (
    .clk           (clk),
    .rst_n         (rst_int_n),
    .enable        (rx_en),
    .rx_sd         (rx_sd),
    .hunt          (hunt),
    .frame_len     (frame_len),
    .sync_pat      (sync_pat),
    .frame         (frame),
    .hunt_hit      (hunt_hit),
    .char_done     (char_done),
    .frame_is_sync (frame_is_sync)
  );

  bsr_sync_fsm u_fsm (
    .clk           (clk),
    .rst_n         (rst_int_n),
    .enable        (rx_en),
    .strip_en      (strip_en),
    .hunt_hit      (hunt_hit),
    .char_done     (char_done),
    .frame_is_sync (frame_is_sync),
    .hunt          (hunt),
    .crc_clr       (crc_clr),
    .deliver       (deliver),
    .sync_det      (sync_det),
    .rx_active     (rx_active)
  );

  bsr_char_check #(.MAX_W(MAX_W)) u_check (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .enable   (rx_en),
    .chk_mode (chk_mode),
    .par_odd  (par_odd),
    .frame    (frame),
    .data_len (data_len),
    .crc_clr  (crc_clr),
    .deliver  (deliver),
    .data     (data),
    .vrc_bad  (vrc_bad),
    .crc_ok   (crc_ok)
  );

  bsr_host_regs #(.MAX_W(MAX_W)) u_regs (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .enable     (rx_en),
    .deliver    (deliver),
    .data       (data),
    .vrc_bad    (vrc_bad),
    .crc_ok     (crc_ok),
    .rd_data    (rd_data),
    .rd_stat    (rd_stat),
    .rx_char    (rx_char),
    .data_avail (data_avail),
    .stat_avail (stat_avail),
    .st_overrun (st_overrun),
    .st_error   (st_error)
  );

endmodule

// File: rtl/bsync_rx_checker.sv
module bsync_rx_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       rx_en,
  input logic [1:0] chk_mode,
  input logic       rd_stat,
  input logic       data_avail,
  input logic       stat_avail,
  input logic       st_overrun,
  input logic       st_error,
  input logic       sync_det,
  input logic       rx_active
);

  assert_sync_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
    sync_det |=> !sync_det);

  assert_en_clear_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_en |=> (!rx_active && !data_avail && !stat_avail && !st_overrun));

  assert_active_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_active && rx_en) |=> rx_active);

  assert_data_when_active_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(data_avail) |-> rx_active);

  assert_overrun_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (st_overrun && !rd_stat && rx_en) |=> st_overrun);

  assert_stat_cause_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stat_avail) |-> (st_overrun || st_error));

  assert_crc_no_stat_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ((chk_mode == 2'b10) && $rose(stat_avail)) |-> st_overrun);

endmodule

bind bsync_rx bsync_rx_checker u_chk (.*);

// File: tb/bsync_rx_tb.sv
module bsync_rx_tb;

  logic       clk;
  logic       rst_n;
  logic       rx_en;
  logic       rx_sd;
  logic [7:0] sync_pat;
  logic [1:0] len_sel;
  logic       strip_en;
  logic [1:0] chk_mode;
  logic       par_odd;
  logic       rd_data;
  logic       rd_stat;
  logic [7:0] rx_char;
  logic       data_avail, stat_avail, st_overrun, st_error, sync_det, rx_active;

  int checks = 0;
  int errors = 0;
  int sd_cnt = 0;
  bit done   = 0;

  bsync_rx u_dut (.*);

  initial clk = 1'b0;
  always #4 clk = ~clk;   // 125 MHz

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic send_char(input logic [7:0] val, input int n,
                           input bit rd_d, input bit rd_s);
    for (int i = 0; i < n; i++) begin
      rx_sd   = val[i];
      rd_data = rd_d && (i == 0);
      rd_stat = rd_s && (i == 0);
      @(negedge clk);
      if (sync_det) sd_cnt++;
    end
    rd_data = 1'b0;
    rd_stat = 1'b0;
  endtask

  task automatic restart(input logic [7:0] sp, input logic [1:0] ls,
                         input bit strip, input logic [1:0] cm);
    rx_en = 1'b0;
    rx_sd = 1'b1;
    @(negedge clk);
    @(negedge clk);
    check("R11 rx_en low clears rx_active", int'(rx_active), 0);
    check("R11 rx_en low clears data_avail", int'(data_avail), 0);
    sync_pat = sp; len_sel = ls; strip_en = strip; chk_mode = cm; par_odd = 1'b0;
    sd_cnt = 0;
    rx_en = 1'b1;
  endtask

  function automatic logic [15:0] ref_crc(input logic [15:0] c, input logic [7:0] d);
    logic [15:0] r = c;
    for (int i = 0; i < 8; i++) begin
      if (r[0] ^ d[i]) r = (r >> 1) ^ 16'hA001;
      else             r = r >> 1;
    end
    return r;
  endfunction

  task automatic t_hunt_nostrip();
    restart(8'h16, 2'b11, 1'b0, 2'b00);
    send_char(8'h07, 3, 0, 0);
    send_char(8'h16, 8, 0, 0);
    send_char(8'h41, 8, 0, 0);
    check("R1 single sync does not activate", int'(rx_active), 0);
    check("R1 single sync delivers nothing", int'(data_avail), 0);
    sd_cnt = 0;
    send_char(8'h16, 8, 0, 0);
    send_char(8'h16, 8, 0, 0);
    check("R1 inactive before first data", int'(rx_active), 0);
    send_char(8'h16, 8, 0, 0);
    check("R2 sync after pair is data", int'(rx_char), 8'h16);
    check("R6 data_avail set", int'(data_avail), 1);
    check("R1 active on first data", int'(rx_active), 1);
    check("R4 three sync pulses", sd_cnt, 3);
    send_char(8'h41, 8, 1, 0);
    check("R5 eight-bit char", int'(rx_char), 8'h41);
    check("R4 no pulse on data", sd_cnt, 3);
    rd_data = 1'b1;
    @(negedge clk);
    rd_data = 1'b0;
    check("R6 rd_data clears data_avail", int'(data_avail), 0);
    check("R11 stays active", int'(rx_active), 1);
  endtask

  task automatic t_strip();
    restart(8'h16, 2'b11, 1'b1, 2'b00);
    for (int k = 0; k < 4; k++) send_char(8'h16, 8, 0, 0);
    check("R3 stripped syncs not delivered", int'(data_avail), 0);
    check("R3 inactive while stripping", int'(rx_active), 0);
    check("R4 pulse for each stripped sync", sd_cnt, 4);
    send_char(8'h55, 8, 0, 0);
    check("R3 first non-sync delivered", int'(rx_char), 8'h55);
    send_char(8'h16, 8, 1, 0);
    check("R3 mid-message sync kept", int'(rx_char), 8'h16);
    check("R3 mid-message sync avail", int'(data_avail), 1);
  endtask

  task automatic t_five_bit();
    restart(8'hF9, 2'b00, 1'b0, 2'b00);
    send_char(8'h19, 5, 0, 0);
    send_char(8'h19, 5, 0, 0);
    send_char(8'h07, 5, 0, 0);
    check("R5 five-bit char right-aligned", int'(rx_char), 8'h07);
    check("R5 five-bit sync matched on low bits", int'(rx_active), 1);
  endtask

  task automatic t_vrc();
    restart(8'h96, 2'b10, 1'b0, 2'b01);
    send_char(8'h96, 8, 0, 0);
    send_char(8'h96, 8, 0, 0);
    send_char(8'h41, 8, 0, 0);
    check("R8 good parity data", int'(rx_char), 8'h41);
    check("R8 good parity no error", int'(st_error), 0);
    check("R10 no status on good parity", int'(stat_avail), 0);
    send_char(8'h43, 8, 1, 0);
    check("R8 bad parity data stripped", int'(rx_char), 8'h43);
    check("R8 bad parity error", int'(st_error), 1);
    check("R10 status on parity error", int'(stat_avail), 1);
    send_char(8'h41, 8, 1, 1);
    check("R10 rd_stat clears status", int'(stat_avail), 0);
    check("R8 rd_stat clears error", int'(st_error), 0);
    par_odd = 1'b1;
    send_char(8'h43, 8, 1, 0);
    check("R8 odd parity accepted", int'(st_error), 0);
    check("R8 odd parity data", int'(rx_char), 8'h43);
  endtask

  task automatic t_crc();
    logic [15:0] c;
    restart(8'h16, 2'b11, 1'b0, 2'b10);
    send_char(8'h16, 8, 0, 0);
    send_char(8'h16, 8, 0, 0);
    c = ref_crc(16'h0000, 8'h31);
    send_char(8'h31, 8, 0, 0);
    c = ref_crc(c, 8'h32);
    send_char(8'h32, 8, 1, 0);
    check("R9 nonzero remainder no pass", int'(st_error), int'(c == 16'h0000));
    send_char(c[7:0], 8, 1, 0);
    send_char(c[15:8], 8, 1, 0);
    check("R9 pass after check bytes", int'(st_error), 1);
    check("R10 crc pass raises no status", int'(stat_avail), 0);
    send_char(8'h16, 8, 1, 0);
    check("R9 pass lasts one char", int'(st_error), 0);
  endtask

  task automatic t_overrun();
    restart(8'h16, 2'b11, 1'b0, 2'b00);
    send_char(8'h16, 8, 0, 0);
    send_char(8'h16, 8, 0, 0);
    send_char(8'h11, 8, 0, 0);
    send_char(8'h22, 8, 0, 0);
    check("R7 overrun flagged", int'(st_overrun), 1);
    check("R7 old char kept", int'(rx_char), 8'h11);
    check("R10 status on overrun", int'(stat_avail), 1);
    send_char(8'h33, 8, 1, 1);
    check("R7 recovers after reads", int'(rx_char), 8'h33);
    check("R7 rd_stat clears overrun", int'(st_overrun), 0);
    check("R10 status cleared", int'(stat_avail), 0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; rx_en = 1'b0; rx_sd = 1'b1; sync_pat = 8'h00; len_sel = 2'b11;
    strip_en = 1'b0; chk_mode = 2'b00; par_odd = 1'b0; rd_data = 1'b0; rd_stat = 1'b0;
    repeat (3) @(negedge clk);
    check("R12 reset rx_active", int'(rx_active), 0);
    check("R12 reset data_avail", int'(data_avail), 0);
    check("R12 reset stat_avail", int'(stat_avail), 0);
    check("R12 reset rx_char", int'(rx_char), 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_hunt_nostrip();
    t_strip();
    t_five_bit();
    t_vrc();
    t_crc();
    t_overrun();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule